// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory instruction into a stream of word addresses, at most one element per clock. Once started, it walks element numbers from zero up to the vector length minus one and, for each element, forms the address in one of three ways: consecutive words from a base, a base plus a multiple of a scalar stride, or a base plus an offset taken from an index stream. The index stream carries one offset per element and serves both gathers and scatters.

Memory behind the sequencer is split into interleaved banks. A bank is chosen by the low bits of the word address, and each bank is unpipelined. The sequencer keeps a countdown timer for every bank. When the element in hand targets a bank that is still busy, it raises a stall flag and holds that element. Strides that share a factor with the bank count therefore slow down, while odd strides run at one element per clock.

For stores, a per-element mask suppresses the request for each disabled element. That element still uses one cycle and still consumes its index. A one-cycle completion pulse follows the last element. A zero length finishes at once, with no requests.

Top module: `vec_addr_gen`

## Requirements
- R1: Mode value 0 (unit stride) gives element i the address base + i. Elements are handled in increasing order, and the sequencer advances by one element per cycle when nothing stalls.
- R2: Mode values 1 and 3 (constant stride) give element i the address base + i × stride, taken modulo 2^ADDR_W, so a stride of all ones walks downward.
- R3: Mode value 2 (indexed) gives element i the address base + idx_data. One index is consumed per element, in element order, on a cycle where idx_valid and idx_ready are both high. Masked store elements also consume their index. While idx_valid is low the element waits.
- R4: Exactly min(vlen, MAX_VL) elements are handled, and req_elem reports the number of the element being issued. A vlen above MAX_VL (64) is treated as 64.
- R5: req_bank equals the low log2(NUM_BANKS) bits of req_addr. No two requests reach the same bank fewer than BANK_LAT cycles apart. When the pending element targets a busy bank, req_valid stays low, bank_stall is high and the element is held.
- R6: For stores (is_store = 1), an element whose mask bit mask[i] is 0 issues no request but still takes one cycle. Loads ignore the mask.
- R7: done is high for one cycle, on the cycle after the last element is handled. With a length of 0, done is high on the cycle after start, and no request is issued.
- R8: busy is high while elements are outstanding. A start that arrives while busy is high is ignored.
- R9: After reset, busy, req_valid and done are low, and every bank is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 2 | 0 unit, 1/3 stride, 2 indexed |
| is_store | input | 1 | Operation is a store, so the mask applies |
| base | input | ADDR_W | Base word address |
| stride | input | ADDR_W | Stride in words (constant-stride mode) |
| vlen | input | VLR_W | Requested vector length |
| mask | input | MAX_VL | Per-element enable for stores |
| idx_valid | input | 1 | Index offset available |
| idx_data | input | ADDR_W | Index offset for the current element |
| idx_ready | output | 1 | Current index is consumed this cycle |
| req_valid | output | 1 | Address request issued |
| req_addr | output | ADDR_W | Word address |
| req_elem | output | ELEM_W | Element number of the request |
| req_bank | output | BANK_W | Target bank |
| bank_stall | output | 1 | Pending element blocked by a busy bank |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
Several properties are checked on every cycle. Each bank has a gap counter that must show at least BANK_LAT cycles before it takes a new request. No request is issued while idle or while stalled. Within one operation, element numbers strictly increase, and done never coincides with busy. The bench's reference model alone can show that addresses are correct for each mode, that the length is clamped, that masked stores are skipped, that zero-length completes, and that a start arriving mid-operation is ignored. It covers stride 2 and stride 8 conflicts, indexed streams with gaps, and address wraparound.

// File: rtl/vag_pkg.sv
package vag_pkg;
    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_STR2   = 2'd3
    } amode_e;
endpackage

// File: rtl/vag_bank_timer.sv
module vag_bank_timer #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_LAT  = 6,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(BANK_LAT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [BANK_W-1:0]    issue_bank,
    output logic [NUM_BANKS-1:0] bank_busy
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            if (issue && issue_bank == BANK_W'(b)) begin
                cnt_d = CNT_W'(BANK_LAT - 1);
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end else begin
                cnt_d = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign bank_busy[b] = (cnt_q != '0);
    end
endmodule

// File: rtl/vag_addr_mux.sv
module vag_addr_mux #(
    parameter int ADDR_W = 32,
    parameter int BANK_W = 3
) (
    input  logic              use_index,
    input  logic [ADDR_W-1:0] acc,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] idx_off,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank
);
    always_comb begin
        addr = use_index ? (base + idx_off) : acc;
        bank = addr[BANK_W-1:0];
    end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_VL    = 64,
    parameter int VLR_W     = 8,
    parameter int NUM_BANKS = 8,
    parameter int BANK_LAT  = 6,
    localparam int ELEM_W   = $clog2(MAX_VL),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic              is_store,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [VLR_W-1:0]  vlen,
    input  logic [MAX_VL-1:0] mask,
    input  logic              idx_valid,
    input  logic [ADDR_W-1:0] idx_data,
    output logic              idx_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [ELEM_W-1:0] req_elem,
    output logic [BANK_W-1:0] req_bank,
    output logic              bank_stall,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        logic              active;
        logic              done;
        logic [ELEM_W-1:0] elem;
        logic [ELEM_W-1:0] last;
        amode_e            mode;
        logic              store;
        logic [MAX_VL-1:0] mask;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] step;
        logic [ADDR_W-1:0] acc;
    } seq_t;

    seq_t s_d, s_q;

    logic [NUM_BANKS-1:0] bank_busy;
    logic [ADDR_W-1:0]    cur_addr;
    logic [BANK_W-1:0]    cur_bank;
    logic                 idx_mode, need, avail, issue_ok, advance, tgt_busy;
    logic [VLR_W-1:0]     vl_eff;

    vag_addr_mux #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mux (
        .use_index (idx_mode),
        .acc       (s_q.acc),
        .base      (s_q.base),
        .idx_off   (idx_data),
        .addr      (cur_addr),
        .bank      (cur_bank)
    );

    vag_bank_timer #(.NUM_BANKS(NUM_BANKS), .BANK_LAT(BANK_LAT)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (req_valid),
        .issue_bank (cur_bank),
        .bank_busy  (bank_busy)
    );

    always_comb begin
        idx_mode   = (s_q.mode == AM_INDEX);
        need       = !(s_q.store && !s_q.mask[s_q.elem]);
        tgt_busy   = bank_busy[cur_bank];
        avail      = !idx_mode || idx_valid;
        issue_ok   = !need || !tgt_busy;
        advance    = s_q.active && avail && issue_ok;
        req_valid  = s_q.active && avail && need && !tgt_busy;
        bank_stall = s_q.active && avail && need && tgt_busy;
        idx_ready  = s_q.active && idx_mode && issue_ok;
        req_addr   = cur_addr;
        req_bank   = cur_bank;
        req_elem   = s_q.elem;
        busy       = s_q.active;
        done       = s_q.done;
        vl_eff     = (vlen > VLR_W'(MAX_VL)) ? VLR_W'(MAX_VL) : vlen;

        s_d      = s_q;
        s_d.done = 1'b0;
        if (advance) begin
            if (s_q.elem == s_q.last) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
            end else begin
                s_d.elem = s_q.elem + 1'b1;
                s_d.acc  = s_q.acc + s_q.step;
            end
        end else if (!s_q.active && start) begin
            if (vl_eff == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.active = 1'b1;
                s_d.elem   = '0;
                s_d.last   = ELEM_W'(vl_eff - 1'b1);
                s_d.mode   = amode_e'(mode);
                s_d.store  = is_store;
                s_d.mask   = mask;
                s_d.base   = base;
                s_d.step   = (amode_e'(mode) == AM_UNIT) ? ADDR_W'(1) : stride;
                s_d.acc    = base;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{active: 1'b0, done: 1'b0, elem: '0, last: '0, mode: AM_UNIT,
                     store: 1'b0, mask: '0, base: '0, step: '0, acc: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
    parameter int ADDR_W    = 32,
    parameter int MAX_VL    = 64,
    parameter int NUM_BANKS = 8,
    parameter int BANK_LAT  = 6,
    localparam int ELEM_W   = $clog2(MAX_VL),
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int AGE_W    = $clog2(BANK_LAT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ELEM_W-1:0] req_elem,
    input logic [BANK_W-1:0] req_bank,
    input logic              bank_stall,
    input logic              busy,
    input logic              done
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
        logic [AGE_W-1:0] age_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                   age_q <= AGE_W'(BANK_LAT);
            else if (req_valid && req_bank == BANK_W'(b)) age_q <= AGE_W'(1);
            else if (age_q < AGE_W'(BANK_LAT))            age_q <= age_q + 1'b1;
        end

        AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_bank == BANK_W'(b)) |-> (age_q >= AGE_W'(BANK_LAT))); // R5
    end

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R8

    AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bank_stall |-> !req_valid); // R5

    AST_ELEM_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && $past(req_valid) && $past(busy)) |-> (req_elem > $past(req_elem))); // R1

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
endmodule

bind vec_addr_gen vag_checker #(
    .ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .NUM_BANKS(NUM_BANKS), .BANK_LAT(BANK_LAT)
) u_vag_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_elem(req_elem),
    .req_bank(req_bank), .bank_stall(bank_stall), .busy(busy), .done(done)
);

// File: tb/tb_vec_addr_gen.sv
module tb_vec_addr_gen;
    localparam int AW = 32, MVL = 64, VW = 8, NB = 8, LAT = 6;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] mode = '0;
    logic is_store = 1'b0;
    logic [AW-1:0] base = '0, stride = '0, idx_data = '0;
    logic [VW-1:0] vlen = '0;
    logic [MVL-1:0] mask = '0;
    logic idx_valid = 1'b0;
    logic idx_ready, req_valid, bank_stall, busy, done;
    logic [AW-1:0] req_addr;
    logic [5:0] req_elem;
    logic [2:0] req_bank;

    always #5 clk = ~clk;

    vec_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_store(is_store),
        .base(base), .stride(stride), .vlen(vlen), .mask(mask),
        .idx_valid(idx_valid), .idx_data(idx_data), .idx_ready(idx_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_elem(req_elem),
        .req_bank(req_bank), .bank_stall(bank_stall), .busy(busy), .done(done)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model state
    bit m_en = 0, m_active = 0, m_done = 0, m_store = 0;
    int m_elem = 0, m_vl = 0, m_mode = 0, ops_done = 0;
    logic [MVL-1:0] m_mask = '0;
    logic [AW-1:0] m_base = '0, m_stride = '0;
    longint free_at [NB];
    longint cyc = 0;
    logic [AW-1:0] idx_q [$];
    bit gap_en = 0;
    int gap_cnt = 0;

    initial for (int b = 0; b < NB; b++) free_at[b] = 0;

    always @(negedge clk) begin
        if (idx_q.size() > 0) begin
            idx_data  = idx_q[0];
            idx_valid = !(gap_en && (gap_cnt % 3 == 2));
        end else begin
            idx_valid = 1'b0;
        end
        gap_cnt++;
    end

    task automatic model_step();
        logic [AW-1:0] a;
        int bk;
        bit need, avail, bfree, e_req, e_stall, e_ir, adv;
        string atag;
        a = '0; need = 0; avail = 0; bfree = 0; bk = 0;
        if (m_active) begin
            if (m_mode == 0)      a = m_base + AW'(m_elem);
            else if (m_mode == 2) a = m_base + idx_data;
            else                  a = m_base + AW'(m_elem) * m_stride;
            bk    = int'(a % NB);
            need  = !(m_store && !m_mask[m_elem]);
            avail = (m_mode != 2) || idx_valid;
            bfree = (cyc >= free_at[bk]);
        end
        e_req   = m_active && avail && need && bfree;
        e_stall = m_active && avail && need && !bfree;
        e_ir    = m_active && (m_mode == 2) && (!need || bfree);
        adv     = m_active && avail && (!need || bfree);
        atag    = (m_mode == 2) ? "R3" : ((m_mode == 0) ? "R1" : "R2");

        chk(req_valid == e_req, (m_active && !need) ? "R6" : "R5", "req_valid", req_valid, e_req);
        if (e_req && req_valid) begin
            chk(req_addr == a, atag, "req_addr", req_addr, a);
            chk(int'(req_elem) == m_elem, "R4", "req_elem", req_elem, m_elem);
            chk(int'(req_bank) == bk, "R5", "req_bank", req_bank, bk);
        end
        chk(bank_stall == e_stall, "R5", "bank_stall", bank_stall, e_stall);
        chk(idx_ready == e_ir, "R3", "idx_ready", idx_ready, e_ir);
        chk(done == m_done, "R7", "done", done, m_done);
        chk(busy == m_active, "R8", "busy", busy, m_active);

        if (m_done) ops_done++;
        if (idx_valid && e_ir && idx_q.size() > 0) void'(idx_q.pop_front());
        if (e_req) free_at[bk] = cyc + LAT;
        m_done = 0;
        if (adv) begin
            if (m_elem == m_vl - 1) begin m_active = 0; m_done = 1; end
            else m_elem++;
        end else if (!m_active && start) begin
            m_vl = (int'(vlen) > MVL) ? MVL : int'(vlen);
            if (m_vl == 0) m_done = 1;
            else begin
                m_active = 1; m_elem = 0; m_mode = int'(mode); m_store = is_store;
                m_mask = mask; m_base = base; m_stride = stride;
            end
        end
        cyc++;
    endtask

    always @(negedge clk) begin
        #4;
        if (m_en) model_step();
    end

    task automatic run_op(int md, bit st, logic [AW-1:0] b, logic [AW-1:0] s,
                          int vl, logic [MVL-1:0] mk);
        int target;
        @(negedge clk);
        mode = 2'(md); is_store = st; base = b; stride = s; vlen = VW'(vl); mask = mk;
        start = 1;
        target = ops_done + 1;
        @(negedge clk);
        start = 0;
        while (ops_done < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int target;
        repeat (3) @(negedge clk);
        #4;
        // R9: outputs quiet during reset
        chk(busy == 0, "R9", "busy in reset", busy, 0);
        chk(req_valid == 0, "R9", "req_valid in reset", req_valid, 0);
        chk(done == 0, "R9", "done in reset", done, 0);
        @(negedge clk);
        rst_n = 1;
        m_en = 1;
        repeat (2) @(negedge clk);

        run_op(0, 0, 32'd100, 32'd0, 16, '0);                 // R1 unit stride
        run_op(1, 0, 32'd7, 32'd3, 10, '0);                   // R2 odd stride, no stall
        run_op(1, 0, 32'd0, 32'd2, 8, '0);                    // R5 stride 2 revisits banks
        run_op(3, 0, 32'd5, 32'd8, 4, '0);                    // R5 stride 8 one bank
        run_op(1, 1, 32'd40, 32'd1, 12, 64'h0A5);             // R6 masked store
        run_op(1, 0, 32'd40, 32'd1, 12, 64'h0);               // R6 load ignores mask
        run_op(1, 0, 32'd3, 32'hFFFF_FFFF, 6, '0);            // R2 downward wrap
        for (int i = 0; i < 12; i++) idx_q.push_back(AW'((i * 5 + 3) % 37));
        gap_en = 1;
        run_op(2, 0, 32'd1000, 32'd0, 12, '0);                // R3 gather with gaps
        for (int i = 0; i < 8; i++) idx_q.push_back(AW'(i * 8));
        run_op(2, 1, 32'd16, 32'd0, 8, 64'h0D);               // R3 scatter masked
        gap_en = 0;
        run_op(0, 0, 32'd9, 32'd0, 0, '0);                    // R7 zero length
        run_op(0, 0, 32'd200, 32'd0, 100, '0);                // R4 clamp to 64

        // R8: start while busy is ignored
        @(negedge clk);
        mode = 2'd1; is_store = 0; base = 32'd50; stride = 32'd3; vlen = 8'd10; mask = '0;
        start = 1;
        target = ops_done + 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        base = 32'd999; vlen = 8'd2; start = 1;
        @(negedge clk);
        start = 0;
        while (ops_done < target) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(ops_done == target, "R8", "extra operation ran", ops_done, target);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule